// File: doc/BRIEF.md
# Debug Entry Cause Resolver

When a processor hart drops into debug mode, several reasons can apply in the same cycle: a debug-entering ebreak, a trigger hit, an external halt request, a finished single step, a halt right out of reset, or membership of a halted group. This block picks the single reason to report, following a fixed priority that does not match the numeric order of the cause codes. It presents that code combinationally and also holds a registered copy that feeds the cause field of the debug status register.

An ebreak only counts as a reason when the control logic says that this ebreak is the one entering debug mode. If an ebreak traps to an ordinary exception instead, for example while single stepping over it, its flag is ignored and a lower-priority reason such as the step is reported. A parameter lets the reset-halt and halt-group reasons report the generic halt-request code instead of their own codes.

Top module: `dbg_cause_resolver`

## Requirements
- R1: Cause codes are 1 ebreak, 2 trigger, 3 halt request, 4 single step, 5 reset-halt, 6 halt group. With no qualified reason the code is 0, and code 7 never appears.
- R2: With several qualified reasons, the code of the strongest one is reported. The order from strongest to weakest is halt group, trigger, ebreak, reset-halt, halt request, single step.
- R3: The ebreak flag counts only while `ebrk_enters_dbg` is high. Otherwise it has no effect on `cause_o` or `cause_q_o`, and weaker reasons win.
- R4: `cause_o` follows the request inputs in the same cycle, with no clock edge in between.
- R5: At a rising clock edge with `save_cause` high and at least one qualified reason, `cause_q_o` takes the value `cause_o` had before the edge.
- R6: With `save_cause` high and no qualified reason, `cause_q_o` keeps its value.
- R7: With `save_cause` low, `cause_q_o` keeps its value whatever the request inputs are.
- R8: While `rst_n` is low, `cause_q_o` is 0, even if `save_cause` and requests are high.
- R9: With `HALT_ALIAS` = 1, reset-halt and halt group report code 3. Their place in the priority order of R2 does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ebreak_req | input | 1 | An ebreak instruction was executed |
| ebrk_enters_dbg | input | 1 | The executed ebreak is the one taking the hart into debug mode |
| trig_req | input | 1 | A trigger fired with the enter-debug action |
| halt_req | input | 1 | External debugger halt request |
| step_req | input | 1 | A single step has completed |
| rsthalt_req | input | 1 | Halt requested directly out of reset |
| grp_req | input | 1 | Halt caused by halt-group membership |
| save_cause | input | 1 | Strobe that loads the registered cause |
| cause_o | output | 3 | Combinational resolved cause code |
| cause_q_o | output | 3 | Registered cause code |

## Verification
The clocked assertions assume that the request flags and strobes are synchronous to `clk`, hold known values once reset is released, and settle before the rising edge they affect. The bench changes every input only just after a falling edge. It checks the combinational code one time unit later and the registered code at the next falling edge, so each sample lands half a period away from the edge that acts on the value. All 64 flag combinations run with ebreak qualification both on and off, on two instances that differ only in `HALT_ALIAS`.

// File: rtl/dbg_cause_pkg.sv
package dbg_cause_pkg;

    typedef logic [2:0] cause_t;

    localparam cause_t CAUSE_NONE    = 3'd0;
    localparam cause_t CAUSE_EBREAK  = 3'd1;
    localparam cause_t CAUSE_TRIGGER = 3'd2;
    localparam cause_t CAUSE_HALT    = 3'd3;
    localparam cause_t CAUSE_STEP    = 3'd4;
    localparam cause_t CAUSE_RSTHALT = 3'd5;
    localparam cause_t CAUSE_GROUP   = 3'd6;

    // number of debug-entry reasons, indexed by priority rank (0 = strongest)
    localparam int NUM_RANKS = 6;
    localparam int RANK_GROUP   = 0;
    localparam int RANK_TRIGGER = 1;
    localparam int RANK_EBREAK  = 2;
    localparam int RANK_RSTHALT = 3;
    localparam int RANK_HALT    = 4;
    localparam int RANK_STEP    = 5;

    // code reported for a given rank, optionally folding reset-halt and
    // halt-group onto the plain halt-request code
    function automatic cause_t rank_code(input int rank, input bit alias_halt);
        cause_t c;
        case (rank)
            RANK_GROUP:   c = alias_halt ? CAUSE_HALT : CAUSE_GROUP;
            RANK_TRIGGER: c = CAUSE_TRIGGER;
            RANK_EBREAK:  c = CAUSE_EBREAK;
            RANK_RSTHALT: c = alias_halt ? CAUSE_HALT : CAUSE_RSTHALT;
            RANK_HALT:    c = CAUSE_HALT;
            RANK_STEP:    c = CAUSE_STEP;
            default:      c = CAUSE_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dbg_cause_pick.sv
// Fixed-priority one-hot grant: rank 0 wins over every higher rank index.
module dbg_cause_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    // blocked[i] is high when some rank below i requests
    logic [N-1:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_rank
        if (i > 0) begin : g_chain
            assign blocked[i] = blocked[i-1] | req[i-1];
        end
        assign grant[i] = req[i] & ~blocked[i];
    end

endmodule

// File: rtl/dbg_cause_enc.sv
// Maps a one-hot rank grant onto the architectural cause code.
module dbg_cause_enc
    import dbg_cause_pkg::*;
#(
    parameter bit HALT_ALIAS = 1'b0
) (
    input  logic [NUM_RANKS-1:0] grant,
    output cause_t               code
);

    always_comb begin
        code = CAUSE_NONE;
        for (int i = 0; i < NUM_RANKS; i++) begin
            if (grant[i]) begin
                code = code | rank_code(i, HALT_ALIAS);
            end
        end
    end

endmodule

// File: rtl/dbg_cause_resolver.sv
module dbg_cause_resolver
    import dbg_cause_pkg::*;
#(
    parameter bit HALT_ALIAS = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ebreak_req,
    input  logic       ebrk_enters_dbg,
    input  logic       trig_req,
    input  logic       halt_req,
    input  logic       step_req,
    input  logic       rsthalt_req,
    input  logic       grp_req,
    input  logic       save_cause,
    output logic [2:0] cause_o,
    output logic [2:0] cause_q_o
);

    typedef struct packed {
        cause_t cause;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_RANKS-1:0] rank_req;
    logic [NUM_RANKS-1:0] rank_grant;
    cause_t               code_w;
    logic                 any_req;

    // ebreak only counts when it is the instruction actually entering debug
    always_comb begin
        rank_req               = '0;
        rank_req[RANK_GROUP]   = grp_req;
        rank_req[RANK_TRIGGER] = trig_req;
        rank_req[RANK_EBREAK]  = ebreak_req & ebrk_enters_dbg;
        rank_req[RANK_RSTHALT] = rsthalt_req;
        rank_req[RANK_HALT]    = halt_req;
        rank_req[RANK_STEP]    = step_req;
    end

    dbg_cause_pick #(.N(NUM_RANKS)) u_pick (
        .req   (rank_req),
        .grant (rank_grant)
    );

    dbg_cause_enc #(.HALT_ALIAS(HALT_ALIAS)) u_enc (
        .grant (rank_grant),
        .code  (code_w)
    );

    assign any_req = |rank_req;

    always_comb begin
        state_d = state_q;
        if (save_cause && any_req) begin
            state_d.cause = code_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{cause: CAUSE_NONE};
        end else begin
            state_q <= state_d;
        end
    end

    assign cause_o   = code_w;
    assign cause_q_o = state_q.cause;

    // R1
    no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_o != 3'd7);

    // R1
    none_means_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rank_grant == '0) |-> (cause_o == CAUSE_NONE));

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rank_grant));

    // R2
    group_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_req |-> (cause_o == (HALT_ALIAS ? CAUSE_HALT : CAUSE_GROUP)));

    // R3
    ebreak_unqualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ebreak_req && !ebrk_enters_dbg && !trig_req && !halt_req && !step_req
         && !rsthalt_req && !grp_req) |-> (cause_o == CAUSE_NONE));

    // R5
    load_on_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_cause && cause_o != CAUSE_NONE) |=> (cause_q_o == $past(cause_o)));

    // R7
    hold_without_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !save_cause |=> $stable(cause_q_o));

endmodule

// File: tb/dbg_cause_resolver_test.sv
`timescale 1ns/1ps
module dbg_cause_resolver_test;

    logic clk = 1'b0;
    logic rst_n;
    logic ebreak_req, ebrk_enters_dbg, trig_req, halt_req, step_req;
    logic rsthalt_req, grp_req, save_cause;
    logic [2:0] cause_a, cause_q_a, cause_b, cause_q_b;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dbg_cause_resolver #(.HALT_ALIAS(1'b0)) uut (
        .clk, .rst_n, .ebreak_req, .ebrk_enters_dbg, .trig_req, .halt_req,
        .step_req, .rsthalt_req, .grp_req, .save_cause,
        .cause_o(cause_a), .cause_q_o(cause_q_a)
    );

    dbg_cause_resolver #(.HALT_ALIAS(1'b1)) uut_alias (
        .clk, .rst_n, .ebreak_req, .ebrk_enters_dbg, .trig_req, .halt_req,
        .step_req, .rsthalt_req, .grp_req, .save_cause,
        .cause_o(cause_b), .cause_q_o(cause_q_b)
    );

    // bench flag bits: [0] ebreak [1] trigger [2] halt [3] step [4] reset-halt [5] group
    function automatic logic [2:0] ref_cause(input logic [5:0] f, input logic en,
                                             input logic alias_m);
        if (f[5])             return alias_m ? 3'd3 : 3'd6;
        else if (f[1])        return 3'd2;
        else if (f[0] && en)  return 3'd1;
        else if (f[4])        return alias_m ? 3'd3 : 3'd5;
        else if (f[2])        return 3'd3;
        else if (f[3])        return 3'd4;
        else                  return 3'd0;
    endfunction

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] f, input logic en, input logic sv);
        ebreak_req      = f[0];
        trig_req        = f[1];
        halt_req        = f[2];
        step_req        = f[3];
        rsthalt_req     = f[4];
        grp_req         = f[5];
        ebrk_enters_dbg = en;
        save_cause      = sv;
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [2:0] exp_a, exp_b, ea, eb;
        rst_n = 1'b0;
        drive(6'd0, 1'b0, 1'b0);
        exp_a = 3'd0;
        exp_b = 3'd0;

        // R8: reset holds the register at zero even with save and requests high
        @(negedge clk);
        drive(6'b100000, 1'b1, 1'b1);
        @(negedge clk);
        chk("R8 reset value", cause_q_a, 3'd0);
        chk("R8 reset value alias", cause_q_b, 3'd0);
        drive(6'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 after release", cause_q_a, 3'd0);
        chk("R1 idle code", cause_a, 3'd0);

        // R1: each reason alone gives its own code
        for (int k = 0; k < 6; k++) begin
            drive(6'(1 << k), 1'b1, 1'b0);
            #1;
            chk("R1 single reason", cause_a, ref_cause(6'(1 << k), 1'b1, 1'b0));
            @(negedge clk);
        end

        // R4: output tracks inputs with no clock edge in between
        drive(6'b001000, 1'b0, 1'b0);
        #1 chk("R4 comb step", cause_a, 3'd4);
        drive(6'b001010, 1'b0, 1'b0);
        #1 chk("R4 comb trigger", cause_a, 3'd2);
        @(negedge clk);

        // R2/R3/R5/R6/R9: full sweep, ebreak qualification off and on
        for (int en = 0; en < 2; en++) begin
            for (int f = 0; f < 64; f++) begin
                drive(6'(f), 1'(en), 1'b1);
                ea = ref_cause(6'(f), 1'(en), 1'b0);
                eb = ref_cause(6'(f), 1'(en), 1'b1);
                #1;
                if (6'(f) == 6'b000001 && en == 0)
                    chk("R3 lone unqualified ebreak", cause_a, ea);
                else
                    chk("R2 priority", cause_a, ea);
                chk("R9 alias priority", cause_b, eb);
                if (ea != 3'd0) exp_a = ea;
                if (eb != 3'd0) exp_b = eb;
                @(negedge clk);
                if (ea == 3'd0)
                    chk("R6 hold on empty save", cause_q_a, exp_a);
                else
                    chk("R5 load on save", cause_q_a, exp_a);
                chk("R5 load on save alias", cause_q_b, exp_b);
                // R7: no save, all flags high, register must not move
                drive(6'b111111, 1'b1, 1'b0);
                @(negedge clk);
                chk("R7 hold without save", cause_q_a, exp_a);
            end
        end

        // R3: unqualified ebreak lets the step reason through to the register
        drive(6'b001001, 1'b0, 1'b1);
        @(negedge clk);
        chk("R3 step over trapping ebreak", cause_q_a, 3'd4);
        drive(6'b001001, 1'b1, 1'b1);
        @(negedge clk);
        chk("R3 qualified ebreak beats step", cause_q_a, 3'd1);
        drive(6'd0, 1'b0, 1'b0);
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule